// File: doc/BRIEF.md
# Wide Register Atomic Byte Bridge

This block connects an 8-bit CPU data port to a single peripheral register that is two, three or four bytes wide. The register occupies consecutive byte addresses starting at a base address, with byte 0 (least significant) at the base. A CPU that can only move one byte at a time still sees the wide value change or be sampled as a whole. Byte writes below the top byte are held in shadow bytes. The write to the top byte moves the shadow bytes and the new top byte into the register on one clock edge. A read of byte 0 freezes the upper bytes into the same shadow bytes, so the later upper-byte reads belong to the same sample.

The shadow bytes also sit at their own addresses, directly after the register bytes, so software can save and restore them. The peripheral can load a new value into the register on any cycle. A CPU commit on the same cycle overrides that load. Software must access byte 0 first and the top byte last. Any interrupt handling needed around such a sequence belongs to the system, not to this block.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, reg_value equals the parameter RESET_VAL and every shadow byte reads as 0x00.
- R2: A CPU write to register byte offset k, with k below NBYTES-1, stores the data in shadow slot k and leaves reg_value unchanged, however long the top byte stays unwritten.
- R3: A CPU write to offset NBYTES-1 loads reg_value with {write data, slot NBYTES-2, ..., slot 0} on that clock edge.
- R4: A CPU read of offset 0 returns reg_value bits 7:0 in the same cycle and, on that edge, copies register byte j+1 into shadow slot j for every slot.
- R5: A CPU read of offset k, with 1 <= k <= NBYTES-1, returns shadow slot k-1 and not the live register.
- R6: A peripheral load between the offset-0 read and the upper-byte reads does not alter the values those reads return.
- R7: When per_load is high, reg_value takes per_data on the next edge unless a top-byte CPU write happens in the same cycle, in which case the CPU commit wins.
- R8: Offset NBYTES+j, for 0 <= j <= NBYTES-2, reads and writes shadow slot j directly, without touching reg_value.
- R9: A read from an address outside BASE_ADDR .. BASE_ADDR+2*NBYTES-2 returns 0x00, and a write there changes neither reg_value nor any shadow slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per byte |
| cpu_rd | input | 1 | CPU read strobe, one cycle per byte |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from the address |
| per_load | input | 1 | Peripheral request to load reg_value |
| per_data | input | 8*NBYTES | Value the peripheral loads |
| reg_value | output | 8*NBYTES | Live wide register |

## Verification
Writes are tried in three orders. The first stages bytes through the register offsets. The second stages them through the direct shadow offsets. The third leaves the top byte unwritten indefinitely. Together these show whether commit happens only on the top byte, and whether both paths into the shadow slots feed it. Reads are run with the peripheral reloading the register between the low-byte read and the upper-byte reads, which separates a true snapshot from a live pass-through. A load and a commit on the same cycle show the priority. Accesses just below and just above the decoded window show that address matching is bounded at both ends.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   localparam int BYTE_W    = 8;
   localparam int MIN_BYTES = 2;
   localparam int MAX_BYTES = 4;

   typedef logic [BYTE_W-1:0] byte_t;

   // Number of decoded byte offsets: register bytes plus directly addressed shadow slots.
   function automatic int span_of(input int nbytes);
      return 2 * nbytes - 1;
   endfunction
endpackage

// File: rtl/wrb_addr_decode.sv
module wrb_addr_decode
   import wrb_pkg::*;
#(
   parameter int NBYTES    = 4,
   parameter int ADDR_W    = 6,
   parameter int BASE_ADDR = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NBYTES-1:0] sel_reg,
   output logic [NBYTES-2:0] sel_tmp,
   output logic              in_range
);
   localparam int SPAN = span_of(NBYTES);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   logic [ADDR_W-1:0] off;

   always_comb begin
      off      = addr - BASE;
      in_range = (addr >= BASE) && (off < ADDR_W'(SPAN));
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_reg_sel
      assign sel_reg[k] = in_range && (off == ADDR_W'(k));
   end

   for (genvar j = 0; j < NBYTES - 1; j++) begin : g_tmp_sel
      assign sel_tmp[j] = in_range && (off == ADDR_W'(NBYTES + j));
   end
endmodule

// File: rtl/wrb_temp_bank.sv
module wrb_temp_bank
   import wrb_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic                          rd,
   input  byte_t                         wdata,
   input  logic [NBYTES-1:0]             sel_reg,
   input  logic [NBYTES-2:0]             sel_tmp,
   input  logic [BYTE_W*NBYTES-1:BYTE_W] live_upper,
   output logic [BYTE_W*(NBYTES-1)-1:0]  tmp
);
   logic snap;
   assign snap = rd && sel_reg[0];

   for (genvar j = 0; j < NBYTES - 1; j++) begin : g_slot
      logic  wr_hit;
      byte_t slot_q;

      // Either the register offset j or the direct offset of slot j writes it.
      assign wr_hit = wr && (sel_reg[j] || sel_tmp[j]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (wr_hit) begin
            slot_q <= wdata;
         end else if (snap) begin
            slot_q <= live_upper[BYTE_W*(j+1) +: BYTE_W];
         end
      end

      assign tmp[BYTE_W*j +: BYTE_W] = slot_q;
   end
endmodule

// File: rtl/wrb_live_reg.sv
module wrb_live_reg
   import wrb_pkg::*;
#(
   parameter int                      NBYTES    = 4,
   parameter logic [8*NBYTES-1:0]     RESET_VAL = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit,
   input  byte_t                        top_byte,
   input  logic [BYTE_W*(NBYTES-1)-1:0] tmp,
   input  logic                         per_load,
   input  logic [BYTE_W*NBYTES-1:0]     per_data,
   output logic [BYTE_W*NBYTES-1:0]     value
);
   logic [BYTE_W*NBYTES-1:0] value_q;
   logic [BYTE_W*NBYTES-1:0] value_d;

   always_comb begin
      value_d = value_q;
      if (commit) begin
         value_d = {top_byte, tmp};
      end else if (per_load) begin
         value_d = per_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= RESET_VAL;
      end else begin
         value_q <= value_d;
      end
   end

   assign value = value_q;
endmodule

// File: rtl/wrb_read_mux.sv
module wrb_read_mux
   import wrb_pkg::*;
#(
   parameter int NBYTES = 4
) (
   input  logic [NBYTES-1:0]             sel_reg,
   input  logic [NBYTES-2:0]             sel_tmp,
   input  byte_t                         live_low,
   input  logic [BYTE_W*(NBYTES-1)-1:0]  tmp,
   output byte_t                         rdata
);
   byte_t part [NBYTES-1];

   // Slot j is reachable through register offset j+1 and through its direct offset.
   for (genvar j = 0; j < NBYTES - 1; j++) begin : g_part
      assign part[j] = (sel_reg[j+1] || sel_tmp[j]) ? tmp[BYTE_W*j +: BYTE_W] : '0;
   end

   always_comb begin
      rdata = sel_reg[0] ? live_low : '0;
      for (int j = 0; j < NBYTES - 1; j++) begin
         rdata = rdata | part[j];
      end
   end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
   import wrb_pkg::*;
#(
   parameter int                  NBYTES    = 4,
   parameter int                  ADDR_W    = 6,
   parameter int                  BASE_ADDR = 16,
   parameter logic [8*NBYTES-1:0] RESET_VAL = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic                  cpu_wr,
   input  logic                  cpu_rd,
   input  logic [7:0]            cpu_wdata,
   output logic [7:0]            cpu_rdata,
   input  logic                  per_load,
   input  logic [8*NBYTES-1:0]   per_data,
   output logic [8*NBYTES-1:0]   reg_value
);
   localparam int W    = BYTE_W * NBYTES;
   localparam int TW   = BYTE_W * (NBYTES - 1);
   localparam int SPAN = span_of(NBYTES);

   // Elaboration checks on the parameter set.
   if (NBYTES < MIN_BYTES || NBYTES > MAX_BYTES) begin : g_bad_width
      $error("wide_reg_bridge: NBYTES must be 2, 3 or 4");
   end
   if (BASE_ADDR < 0 || BASE_ADDR + SPAN > (1 << ADDR_W)) begin : g_bad_base
      $error("wide_reg_bridge: decoded window does not fit in ADDR_W");
   end

   logic [NBYTES-1:0] sel_reg;
   logic [NBYTES-2:0] sel_tmp;
   logic              in_range;
   logic [TW-1:0]     tmp;
   logic              commit;

   wrb_addr_decode #(
      .NBYTES    (NBYTES),
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .addr     (cpu_addr),
      .sel_reg  (sel_reg),
      .sel_tmp  (sel_tmp),
      .in_range (in_range)
   );

   wrb_temp_bank #(
      .NBYTES (NBYTES)
   ) u_tmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cpu_wr),
      .rd         (cpu_rd),
      .wdata      (cpu_wdata),
      .sel_reg    (sel_reg),
      .sel_tmp    (sel_tmp),
      .live_upper (reg_value[W-1:BYTE_W]),
      .tmp        (tmp)
   );

   assign commit = cpu_wr && sel_reg[NBYTES-1];

   wrb_live_reg #(
      .NBYTES    (NBYTES),
      .RESET_VAL (RESET_VAL)
   ) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .top_byte (cpu_wdata),
      .tmp      (tmp),
      .per_load (per_load),
      .per_data (per_data),
      .value    (reg_value)
   );

   wrb_read_mux #(
      .NBYTES (NBYTES)
   ) u_rmux (
      .sel_reg  (sel_reg),
      .sel_tmp  (sel_tmp),
      .live_low (reg_value[BYTE_W-1:0]),
      .tmp      (tmp),
      .rdata    (cpu_rdata)
   );

   // in_range is consumed only by the decoder's own selects.
   logic unused_ok;
   assign unused_ok = in_range;
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
   parameter int NBYTES    = 4,
   parameter int ADDR_W    = 6,
   parameter int BASE_ADDR = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     cpu_addr,
   input logic                  cpu_wr,
   input logic                  cpu_rd,
   input logic [7:0]            cpu_wdata,
   input logic [7:0]            cpu_rdata,
   input logic                  per_load,
   input logic [8*NBYTES-1:0]   per_data,
   input logic [8*NBYTES-1:0]   reg_value
);
   localparam int W = 8 * NBYTES;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(BASE_ADDR + NBYTES - 1);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(BASE_ADDR + 2 * NBYTES - 2);

   logic lower_hit, top_hit, low_hit, outside;
   assign low_hit   = (cpu_addr == BASE);
   assign top_hit   = (cpu_addr == TOP);
   assign lower_hit = (cpu_addr >= BASE) && (cpu_addr < TOP);
   assign outside   = (cpu_addr < BASE) || (cpu_addr > LAST);

   // R2: staging writes leave the live register alone
   a_r2_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && lower_hit && !per_load) |=> $stable(reg_value));

   // R3 and R7: a top-byte write commits even against a peripheral load
   a_r3_top_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && top_hit) |=> (reg_value[W-1:W-8] == $past(cpu_wdata)));

   // R4: low-byte read returns the live byte
   a_r4_low_read_live: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && low_hit) |-> (cpu_rdata == reg_value[7:0]));

   // R7: peripheral load applies when no commit competes
   a_r7_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (per_load && !(cpu_wr && top_hit)) |=> (reg_value == $past(per_data)));

   // R9: addresses outside the window read as zero
   a_r9_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && outside) |-> (cpu_rdata == 8'h00));

   // R9: outside writes do not move the register
   a_r9_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && outside && !per_load) |=> $stable(reg_value));
endmodule

bind wide_reg_bridge wrb_checker #(
   .NBYTES    (NBYTES),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) u_chk (.*);

// File: tb/wide_reg_bridge_tb.sv
module wide_reg_bridge_tb;
   localparam int          NB   = 4;
   localparam int          AW   = 6;
   localparam int          BASE = 16;
   localparam logic [31:0] RV   = 32'h1E0F_C3A5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_wr = 1'b0;
   logic          cpu_rd = 1'b0;
   logic [7:0]    cpu_wdata = '0;
   logic [7:0]    cpu_rdata;
   logic          per_load = 1'b0;
   logic [31:0]   per_data = '0;
   logic [31:0]   reg_value;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   always #5 clk = ~clk;

   wide_reg_bridge #(
      .NBYTES(NB), .ADDR_W(AW), .BASE_ADDR(BASE), .RESET_VAL(RV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .per_load(per_load), .per_data(per_data), .reg_value(reg_value)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input int off, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = AW'(BASE + off); cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_write_abs(input int a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = AW'(a); cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic cpu_read_abs(input int a, output logic [7:0] d);
      @(negedge clk);
      cpu_addr = AW'(a); cpu_rd = 1'b1;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic cpu_read(input int off, output logic [7:0] d);
      cpu_read_abs(BASE + off, d);
   endtask

   task automatic per_push(input logic [31:0] v);
      @(negedge clk);
      per_data = v; per_load = 1'b1;
      @(negedge clk);
      per_load = 1'b0;
   endtask

   task automatic expect_byte(input int off, input logic [7:0] e, input string req);
      logic [7:0] d;
      cpu_read(off, d);
      check(d == e, req, {24'h0, d}, {24'h0, e});
   endtask

   task automatic t_reset;
      check(reg_value == RV, "R1 reset value", reg_value, RV);
      for (int j = 0; j < NB - 1; j++) expect_byte(NB + j, 8'h00, "R1 shadow cleared");
   endtask

   task automatic t_staged_write;
      cpu_write(0, 8'h11);
      check(reg_value == RV, "R2 byte0 staged", reg_value, RV);
      cpu_write(1, 8'h22);
      cpu_write(2, 8'h33);
      check(reg_value == RV, "R2 bytes1-2 staged", reg_value, RV);
      expect_byte(NB + 0, 8'h11, "R8 read slot0");
      expect_byte(NB + 1, 8'h22, "R8 read slot1");
      expect_byte(NB + 2, 8'h33, "R8 read slot2");
      cpu_write(3, 8'h44);
      check(reg_value == 32'h4433_2211, "R3 top commit", reg_value, 32'h4433_2211);
   endtask

   task automatic t_snapshot_read;
      per_push(32'hDEAD_BEEF);
      check(reg_value == 32'hDEAD_BEEF, "R7 peripheral load", reg_value, 32'hDEAD_BEEF);
      expect_byte(0, 8'hEF, "R4 low read live");
      per_push(32'h0102_0304);
      expect_byte(1, 8'hBE, "R5 R6 byte1 from snapshot");
      expect_byte(2, 8'hAD, "R5 R6 byte2 from snapshot");
      expect_byte(3, 8'hDE, "R5 R6 byte3 from snapshot");
      expect_byte(0, 8'h04, "R4 low read new value");
      expect_byte(3, 8'h01, "R4 fresh snapshot byte3");
   endtask

   task automatic t_direct_shadow;
      cpu_write(NB + 0, 8'h5A);
      cpu_write(NB + 1, 8'h6B);
      cpu_write(NB + 2, 8'h7C);
      check(reg_value == 32'h0102_0304, "R8 direct write no effect on reg", reg_value,
            32'h0102_0304);
      cpu_write(3, 8'h8D);
      check(reg_value == 32'h8D7C_6B5A, "R8 R3 commit of direct slots", reg_value,
            32'h8D7C_6B5A);
   endtask

   task automatic t_priority;
      cpu_write(0, 8'h11);
      cpu_write(1, 8'h22);
      cpu_write(2, 8'h33);
      @(negedge clk);
      cpu_addr = AW'(BASE + 3); cpu_wdata = 8'h99; cpu_wr = 1'b1;
      per_data = 32'hCAFE_F00D; per_load = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0; per_load = 1'b0;
      check(reg_value == 32'h9933_2211, "R7 commit beats load", reg_value, 32'h9933_2211);
      per_push(32'hCAFE_F00D);
      check(reg_value == 32'hCAFE_F00D, "R7 load alone", reg_value, 32'hCAFE_F00D);
   endtask

   task automatic t_outside;
      logic [7:0] d;
      cpu_read_abs(BASE + 2 * NB - 1, d);
      check(d == 8'h00, "R9 read above window", {24'h0, d}, 32'h0);
      cpu_read_abs(BASE - 1, d);
      check(d == 8'h00, "R9 read below window", {24'h0, d}, 32'h0);
      cpu_write_abs(BASE + 2 * NB - 1, 8'hFF);
      cpu_write_abs(BASE - 1, 8'hFF);
      check(reg_value == 32'hCAFE_F00D, "R9 outside write reg", reg_value, 32'hCAFE_F00D);
      expect_byte(NB + 0, 8'h11, "R9 outside write slot0");
      expect_byte(NB + 1, 8'h22, "R9 outside write slot1");
      expect_byte(NB + 2, 8'h33, "R9 outside write slot2");
   endtask

   task automatic t_orphan;
      cpu_write(1, 8'h77);
      repeat (30) @(negedge clk);
      check(reg_value == 32'hCAFE_F00D, "R2 orphan write holds", reg_value, 32'hCAFE_F00D);
      expect_byte(NB + 1, 8'h77, "R2 orphan byte in slot1");
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_staged_write();
      t_snapshot_read();
      t_direct_shadow();
      t_priority();
      t_outside();
      t_orphan();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end
endmodule